// File: doc/BRIEF.md
# Two-Lane Interrupt Message Transmitter

This block sends one interrupt message over a shared serial bus that is two bits wide. It moves one bit pair per bus clock. A requester offers the fields of a message in parallel under a valid/ready handshake. The block latches the fields, then drives a fixed 21-cycle frame. The frame holds a start marker, the arbitration ID, the destination mode, delivery mode, level and trigger bits, the vector, the destination, a two-bit checksum, a zero pad, two status cycles and an idle cycle.

During the first status cycle the receivers drive the bus, and the block captures the pair they return. If the message uses lowest-priority delivery and no receiver claimed it, the block raises a flag. The flag means the message must extend to the longer arbitrated form, which a separate stage carries out. In every other case the message ends after cycle 21.

The block also supports the two broadcast shorthands. Both are sent in physical destination mode with an arbitration ID of all ones. They look identical on the bus, so only the requester knows which of the two it asked for.

Top module: `irq_msg_tx`

## Requirements
- R1: After reset and whenever no message is in flight, `bus_out` is 2'b00, `req_ready` is 1, `done` is 0, and `status_out` and `extend_required` are 0 until the first status capture.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Bus cycle 1 is driven in the next clock. `req_ready` stays 0 for all 21 cycles. Any change on the request inputs after acceptance has no effect on the frame.
- R3: In cycle 1, `bus_out` is {bit1,bit0} = 2'b01. In cycles 2, 3, 4 and 5, bit1 carries arbitration ID bits 3, 2, 1 and 0 in that order, and bit0 is 0.
- R4: Cycles 6 to 12 carry {logical,mode[2]}, {mode[1],mode[0]}, {level,trig}, vector[7:6], vector[5:4], vector[3:2] and vector[1:0]. Here logical=1 selects logical destination mode.
- R5: In logical mode, cycles 13 to 16 carry dest[7:6], dest[5:4], dest[3:2] and dest[1:0]. In physical mode, cycles 13 and 14 are 2'b00, and cycles 15 and 16 carry dest[3:2] and dest[1:0], which form the 4-bit target ID.
- R6: Cycle 17 carries the sum, modulo 4, of the two-bit values of cycles 6 to 16. Cycles 18 to 21 are driven as 2'b00.
- R7: A `req_shorthand` of 2'b10 (to all, self included) or 2'b11 (to all, self excluded) forces physical mode, arbitration ID 4'b1111 and target ID 4'b1111. The two codes give identical bus frames. A code of 2'b00 or 2'b01 means no shorthand.
- R8: The `bus_in` pair present in cycle 19 is captured on the edge that ends cycle 19. It appears on `status_out` from cycle 20 and holds until the next acceptance, which clears it to 0. `bus_in` in any other cycle is ignored.
- R9: `extend_required` is set together with the status capture only when the delivery mode is 3'b001 (lowest priority) and the captured pair is 2'b00. Any other mode or status, including error status, ends the message at cycle 21 with the flag at 0.
- R10: `done` is 1 for exactly the clock of cycle 21. The following clock is idle with `req_ready` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_arb_id | input | 4 | Arbitration ID of the sender |
| req_logical | input | 1 | 1 = logical destination, 0 = physical |
| req_mode | input | 3 | Delivery mode (3'b001 = lowest priority) |
| req_level | input | 1 | Level bit |
| req_trig | input | 1 | Trigger mode bit |
| req_vector | input | 8 | Interrupt vector |
| req_dest | input | 8 | Destination (physical uses bits 3:0) |
| req_shorthand | input | 2 | 2'b10 / 2'b11 broadcast shorthands |
| bus_out | output | 2 | Bit pair driven on the bus {bit1,bit0} |
| bus_in | input | 2 | Bit pair seen on the bus |
| done | output | 1 | Final cycle of the message |
| status_out | output | 2 | Status pair captured in cycle 19 |
| extend_required | output | 1 | Message must continue to the arbitrated form |

## Verification
Cycle k of the frame appears on `bus_out` k clocks after the accepting edge. The bench samples each bit pair on the falling edge inside that clock. The status pair comes from cycle 19 and is first checked in cycle 20, one register later, as is `extend_required`. `done` is checked in cycle 21 only, and the idle state on the next falling edge. `bus_in` carries the complement of the status pair in every other cycle, so a capture in the wrong cycle shows up as a mismatch.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

    localparam int CYC_W      = 5;
    localparam int ARB_W      = 4;
    localparam int VEC_W      = 8;
    localparam int DST_W      = 8;
    localparam int MODE_W     = 3;

    localparam int CY_ARB_END  = 5;
    localparam int CY_SUM_LO   = 6;
    localparam int CY_SUM_HI   = 16;
    localparam int CY_CSUM     = 17;
    localparam int CY_PAD      = 18;
    localparam int CY_STAT0    = 19;
    localparam int CY_STAT1    = 20;
    localparam int CY_LAST     = 21;
    localparam int SUM_TERMS   = CY_SUM_HI - CY_SUM_LO + 1;

    typedef logic [CYC_W-1:0] cyc_t;

    typedef struct packed {
        logic [ARB_W-1:0]  arb;
        logic              dm;
        logic [MODE_W-1:0] mode;
        logic              lvl;
        logic              trig;
        logic [VEC_W-1:0]  vec;
        logic [DST_W-1:0]  dst;
    } msg_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HEAD,
        S_BODY,
        S_CSUM,
        S_PAD,
        S_STAT,
        S_TAIL
    } st_t;

    // Bit pair {bit1,bit0} for frame cycles 1..16; zero elsewhere.
    function automatic logic [1:0] frame_pair(input cyc_t c, input msg_t m);
        logic [1:0] p;
        case (c)
            5'd1:    p = 2'b01;
            5'd2:    p = {m.arb[3], 1'b0};
            5'd3:    p = {m.arb[2], 1'b0};
            5'd4:    p = {m.arb[1], 1'b0};
            5'd5:    p = {m.arb[0], 1'b0};
            5'd6:    p = {m.dm, m.mode[2]};
            5'd7:    p = m.mode[1:0];
            5'd8:    p = {m.lvl, m.trig};
            5'd9:    p = m.vec[7:6];
            5'd10:   p = m.vec[5:4];
            5'd11:   p = m.vec[3:2];
            5'd12:   p = m.vec[1:0];
            5'd13:   p = m.dm ? m.dst[7:6] : 2'b00;
            5'd14:   p = m.dm ? m.dst[5:4] : 2'b00;
            5'd15:   p = m.dst[3:2];
            5'd16:   p = m.dst[1:0];
            default: p = 2'b00;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/irq_frame_map.sv
module irq_frame_map
    import irq_msg_pkg::*;
(
    input  cyc_t       cyc,
    input  msg_t       msg,
    output logic [1:0] pair
);
    assign pair = frame_pair(cyc, msg);
endmodule

// File: rtl/irq_frame_csum.sv
module irq_frame_csum
    import irq_msg_pkg::*;
(
    input  msg_t       msg,
    output logic [1:0] csum
);
    logic [1:0] term [SUM_TERMS];

    for (genvar k = 0; k < SUM_TERMS; k++) begin : g_term
        assign term[k] = frame_pair(cyc_t'(CY_SUM_LO + k), msg);
    end

    always_comb begin
        csum = 2'b00;
        for (int i = 0; i < SUM_TERMS; i++) begin
            csum = csum + term[i];
        end
    end
endmodule

// File: rtl/irq_status_eval.sv
module irq_status_eval
    import irq_msg_pkg::*;
#(
    parameter logic [MODE_W-1:0] LOWPRI_MODE = 3'b001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic [1:0]        line,
    input  logic [MODE_W-1:0] mode,
    output logic [1:0]        status,
    output logic              extend
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            status <= 2'b00;
            extend <= 1'b0;
        end else if (capture) begin
            status <= line;
            extend <= (mode == LOWPRI_MODE) && (line == 2'b00);
        end
    end
endmodule

// File: rtl/irq_msg_tx.sv
module irq_msg_tx
    import irq_msg_pkg::*;
#(
    parameter logic [MODE_W-1:0] LOWPRI_MODE = 3'b001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ARB_W-1:0]  req_arb_id,
    input  logic              req_logical,
    input  logic [MODE_W-1:0] req_mode,
    input  logic              req_level,
    input  logic              req_trig,
    input  logic [VEC_W-1:0]  req_vector,
    input  logic [DST_W-1:0]  req_dest,
    input  logic [1:0]        req_shorthand,
    output logic [1:0]        bus_out,
    input  logic [1:0]        bus_in,
    output logic              done,
    output logic [1:0]        status_out,
    output logic              extend_required
);
    st_t        st_q, st_d;
    cyc_t       cyc_q;
    msg_t       msg_q, msg_in;
    logic       accept;
    logic [1:0] body_pair;
    logic [1:0] csum;

    assign accept = req_valid && (st_q == S_IDLE);

    // Broadcast shorthands override mode, arbitration ID and target ID.
    always_comb begin
        msg_in.arb  = req_arb_id;
        msg_in.dm   = req_logical;
        msg_in.mode = req_mode;
        msg_in.lvl  = req_level;
        msg_in.trig = req_trig;
        msg_in.vec  = req_vector;
        msg_in.dst  = req_dest;
        if (req_shorthand[1]) begin
            msg_in.arb = '1;
            msg_in.dm  = 1'b0;
            msg_in.dst = DST_W'(4'hF);
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (accept)                      st_d = S_HEAD;
            S_HEAD: if (cyc_q == cyc_t'(CY_ARB_END)) st_d = S_BODY;
            S_BODY: if (cyc_q == cyc_t'(CY_SUM_HI))  st_d = S_CSUM;
            S_CSUM:                                  st_d = S_PAD;
            S_PAD:                                   st_d = S_STAT;
            S_STAT: if (cyc_q == cyc_t'(CY_STAT1))   st_d = S_TAIL;
            S_TAIL:                                  st_d = S_IDLE;
            default:                                 st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            cyc_q <= '0;
            msg_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                cyc_q <= cyc_t'(1);
                msg_q <= msg_in;
            end else if (st_q == S_TAIL) begin
                cyc_q <= '0;
            end else if (st_q != S_IDLE) begin
                cyc_q <= cyc_q + cyc_t'(1);
            end
        end
    end

    irq_frame_map u_map (
        .cyc  (cyc_q),
        .msg  (msg_q),
        .pair (body_pair)
    );

    irq_frame_csum u_csum (
        .msg  (msg_q),
        .csum (csum)
    );

    irq_status_eval #(.LOWPRI_MODE(LOWPRI_MODE)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .capture ((st_q == S_STAT) && (cyc_q == cyc_t'(CY_STAT0))),
        .line    (bus_in),
        .mode    (msg_q.mode),
        .status  (status_out),
        .extend  (extend_required)
    );

    always_comb begin
        req_ready = (st_q == S_IDLE);
        done      = (st_q == S_TAIL);
        unique case (st_q)
            S_HEAD, S_BODY: bus_out = body_pair;
            S_CSUM:         bus_out = csum;
            default:        bus_out = 2'b00;
        endcase
    end
endmodule

// File: rtl/irq_msg_tx_chk.sv
module irq_msg_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] bus_out,
    input logic       done,
    input logic [1:0] status_out,
    input logic       extend_required
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_out == 2'b00 && !done));

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r8_status_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> $stable(status_out));

    a_r9_extend_only_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        extend_required |-> (status_out == 2'b00));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));
endmodule

bind irq_msg_tx irq_msg_tx_chk u_chk (.*);

// File: tb/irq_msg_tx_tb_top.sv
module irq_msg_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [3:0] req_arb_id = '0;
    logic       req_logical = 1'b0;
    logic [2:0] req_mode = '0;
    logic       req_level = 1'b0;
    logic       req_trig = 1'b0;
    logic [7:0] req_vector = '0;
    logic [7:0] req_dest = '0;
    logic [1:0] req_shorthand = '0;
    logic [1:0] bus_out;
    logic [1:0] bus_in = '0;
    logic       done;
    logic [1:0] status_out;
    logic       extend_required;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [1:0] seen_q[$];
    logic [1:0] keep_q[$];

    always #5 clk = ~clk;

    irq_msg_tx dut_i (.*);

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string tag_for(input int i);
        if (i <= 5)  return "R3";
        if (i <= 12) return "R4";
        if (i <= 16) return "R5";
        return "R6";
    endfunction

    // Sends one message and compares every bus cycle against a model frame.
    task automatic send(input logic [3:0] arb, input logic lg, input logic [2:0] md,
                        input logic lv, input logic tg, input logic [7:0] vec,
                        input logic [7:0] dst, input logic [1:0] sh,
                        input logic [1:0] st, input bit disturb);
        int exp_q[$];
        int a, l, s;
        int d;
        bit ext;
        a = arb; l = lg; d = dst;
        if (sh[1]) begin a = 15; l = 0; d = 15; end
        exp_q.push_back(1);
        for (int b = 3; b >= 0; b--) exp_q.push_back(((a >> b) & 1) * 2);
        exp_q.push_back(l * 2 + md[2]);
        exp_q.push_back(md[1] * 2 + md[0]);
        exp_q.push_back(lv * 2 + tg);
        for (int b = 6; b >= 0; b -= 2) exp_q.push_back((vec >> b) & 3);
        for (int b = 6; b >= 0; b -= 2)
            exp_q.push_back((l == 0 && b >= 4) ? 0 : ((d >> b) & 3));
        s = 0;
        for (int k = 5; k <= 15; k++) s += exp_q[k];
        exp_q.push_back(s % 4);
        repeat (4) exp_q.push_back(0);
        ext = (md == 3'b001) && (st == 2'b00);

        seen_q.delete();
        @(negedge clk);
        req_arb_id = arb; req_logical = lg; req_mode = md; req_level = lv;
        req_trig = tg; req_vector = vec; req_dest = dst; req_shorthand = sh;
        req_valid = 1'b1;
        bus_in = ~st;
        for (int i = 1; i <= 21; i++) begin
            @(negedge clk);
            if (!disturb || i == 21) req_valid = 1'b0;
            if (disturb && i >= 2 && i <= 20) begin
                req_arb_id = ~arb; req_logical = ~lg; req_mode = ~md;
                req_vector = ~vec; req_dest = ~dst; req_shorthand = ~sh;
            end
            bus_in = (i == 19) ? st : ~st;
            seen_q.push_back(bus_out);
            check(disturb ? "R2 frame unchanged" : tag_for(i), int'(bus_out), exp_q[i-1]);
            check("R2 ready low", int'(req_ready), 0);
            check("R10 done", int'(done), (i == 21) ? 1 : 0);
            if (i == 1) check("R8 cleared", int'(status_out), 0);
            if (i >= 20) begin
                check("R8 status", int'(status_out), int'(st));
                check("R9 extend", int'(extend_required), int'(ext));
            end
        end
        @(negedge clk);
        check("R10 idle after", int'(req_ready), 1);
        check("R1 idle bus", int'(bus_out), 0);
        check("R8 status held", int'(status_out), int'(st));
        check("R9 extend held", int'(extend_required), int'(ext));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset ready", int'(req_ready), 1);
        check("R1 reset bus", int'(bus_out), 0);
        check("R1 reset done", int'(done), 0);
        check("R1 reset status", int'(status_out), 0);
        check("R1 reset extend", int'(extend_required), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle ready", int'(req_ready), 1);

        // Fixed mode, physical, error-like status: no extension.
        send(4'h5, 1'b0, 3'b000, 1'b1, 1'b0, 8'hA5, 8'h3C, 2'b00, 2'b11, 1'b0);
        // Lowest priority, logical, nobody claimed: extension (R9).
        send(4'h9, 1'b1, 3'b001, 1'b0, 1'b1, 8'h3E, 8'hB7, 2'b00, 2'b00, 1'b0);
        // Lowest priority, focus claimed: ends at 21 (R9).
        send(4'h2, 1'b1, 3'b001, 1'b1, 1'b1, 8'h41, 8'h6D, 2'b01, 2'b10, 1'b0);
        // Fixed mode with status 00: still no extension (R9).
        send(4'hC, 1'b0, 3'b000, 1'b0, 1'b0, 8'h10, 8'hFF, 2'b00, 2'b00, 1'b0);
        // Checksum wrap with all ones (R6).
        send(4'hF, 1'b1, 3'b111, 1'b1, 1'b1, 8'hFF, 8'hFF, 2'b00, 2'b01, 1'b0);

        // Shorthands R7: both codes must give the same frame.
        send(4'h3, 1'b1, 3'b001, 1'b0, 1'b1, 8'h77, 8'h55, 2'b10, 2'b10, 1'b0);
        keep_q = seen_q;
        send(4'h3, 1'b1, 3'b001, 1'b0, 1'b1, 8'h77, 8'h55, 2'b11, 2'b10, 1'b0);
        for (int i = 0; i < 21; i++)
            check("R7 shorthands identical", int'(seen_q[i]), int'(keep_q[i]));

        // Request inputs toggled during the message are ignored (R2).
        send(4'h6, 1'b1, 3'b001, 1'b1, 1'b0, 8'h9C, 8'h2A, 2'b00, 2'b00, 1'b1);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule